// File: doc/BRIEF.md
# Display Identification Stream Receiver

This block captures the 128-byte identification record that a display sends on its own, one way, over a single serial data line. No request comes from the host. The display's vertical sync acts as the bit clock. The receiver brings sync and data into the system clock domain and turns each rising sync edge into a one-cycle sample strobe. Each byte occupies nine sync clocks: eight data bits, most significant bit first, then one spare bit that the receiver discards.

The record repeats without any start marker. The receiver therefore looks, at every bit position, for the fixed 8-byte opening pattern `00 FF FF FF FF FF FF 00`. When the pattern appears, it locks the byte boundary, stores the remaining 120 bytes and checks that all 128 bytes sum to zero modulo 256. If they do, it raises a valid flag. If not, it gives a one-cycle error pulse and resumes the search. When sync edges stop for longer than a set number of system clocks, the capture is dropped, the valid flag clears and the search restarts.

Host logic reads the captured record through a registered read port that takes a byte address.

The controller has four states:
- `ST_SEARCH`: looks for the opening pattern. Pattern found → `ST_CAPTURE`.
- `ST_CAPTURE`: stores bytes 8 to 127. Byte 127 stored → `ST_CHECK`.
- `ST_CHECK`: tests the sum. Sum zero → `ST_VALID`. Sum non-zero → `ST_SEARCH` with an error pulse.
- `ST_VALID`: holds the record.

From any state, a sync timeout → `ST_SEARCH`.

Top module: `idstream_rx`

## Requirements
- R1: After reset, `valid_o` and `err_o` are 0 and `rd_data_o` is 8'h00.
- R2: A bit is taken on each rising edge of `vsync_i`. A byte is eight data bits, most significant first, followed by a ninth bit whose value has no effect on the stored data.
- R3: Alignment is found at any bit offset. Capture may begin anywhere in the repeating stream, and a complete record that follows is still captured.
- R4: Addresses 0 to 7 read back the opening pattern 00 FF FF FF FF FF FF 00. Addresses 8 to 127 read back the bytes received after the pattern, in arrival order.
- R5: `valid_o` goes to 1 only after all 128 bytes are held and their sum modulo 256 is 0.
- R6: If the sum is non-zero, `err_o` pulses high for exactly one cycle, `valid_o` stays 0 and the search restarts.
- R7: If no rising sync edge arrives for `TIMEOUT_CYC` system clocks, `valid_o` clears and the search restarts. Error pulses are not raised by a timeout.
- R8: A read with `rd_en_i` high returns the addressed byte on `rd_data_o` one cycle later if `valid_o` was 1 in the request cycle. Otherwise, and in every cycle with no request, `rd_data_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | Display vertical sync, used as the bit clock |
| ddc_data_i | input | 1 | Serial identification data from the display |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 7 | Byte address to read |
| rd_data_o | output | 8 | Read data, one cycle after the request |
| valid_o | output | 1 | Stored record is complete and its checksum passed |
| err_o | output | 1 | One-cycle pulse on checksum failure |

## Verification
A host read and the sync timeout can land in the same clock cycle. In that cycle, `valid_o` is still 1, and it falls in the next cycle. To provoke this, the bench stops sync after a valid capture and issues a read on every cycle until the timeout has expired. Each read's expected value is fixed when the request is driven: the addressed byte if `valid_o` is high in that cycle, otherwise zero. The read result must therefore follow the flag as it stood in the request cycle, with no read lost or doubled at the changeover.

// File: rtl/idstream_pkg.sv
package idstream_pkg;

    localparam int REC_BYTES     = 128;
    localparam int HDR_BYTES     = 8;
    localparam int BITS_PER_SLOT = 9;
    localparam int ADDR_W        = $clog2(REC_BYTES);
    localparam int WIN_W         = HDR_BYTES * BITS_PER_SLOT;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_CHECK   = 2'd2,
        ST_VALID   = 2'd3
    } rx_state_t;

    function automatic logic [7:0] hdr_byte(input int k);
        return (k == 0 || k == HDR_BYTES - 1) ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [7:0] hdr_sum();
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < HDR_BYTES; k++) s = s + hdr_byte(k);
        return s;
    endfunction

endpackage

// File: rtl/idstream_edge.sv
module idstream_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic data_i,
    output logic strobe_o,
    output logic bit_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] v_sh;
    logic [MSB:0] d_sh;
    logic         v_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_sh   <= '0;
            d_sh   <= '0;
            v_prev <= 1'b0;
        end else begin
            v_sh   <= {v_sh[MSB-1:0], vsync_i};
            d_sh   <= {d_sh[MSB-1:0], data_i};
            v_prev <= v_sh[MSB];
        end
    end

    assign strobe_o = v_sh[MSB] & ~v_prev;
    assign bit_o    = d_sh[MSB];

    // R2: one strobe per rising sync edge, never two in a row
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/idstream_framer.sv
module idstream_framer
    import idstream_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic       bit_i,
    input  logic       hunt_i,
    input  logic       clear_i,
    output logic       hit_o,
    output logic       byte_done_o,
    output logic [7:0] byte_o
);
    localparam int CNT_W = $clog2(BITS_PER_SLOT);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BITS_PER_SLOT - 1);

    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] nw;
    logic [CNT_W-1:0] cnt;

    function automatic logic hdr_match(input logic [WIN_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < HDR_BYTES; k++) begin
            if (w[(WIN_W - 1 - BITS_PER_SLOT * k) -: 8] != hdr_byte(k)) ok = 1'b0;
        end
        return ok;
    endfunction

    assign nw = {win[WIN_W-2:0], bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win         <= '0;
            cnt         <= '0;
            hit_o       <= 1'b0;
            byte_done_o <= 1'b0;
            byte_o      <= 8'h00;
        end else begin
            hit_o       <= 1'b0;
            byte_done_o <= 1'b0;
            if (clear_i) begin
                win <= '0;
                cnt <= '0;
            end else if (strobe_i) begin
                win <= nw;
                if (hunt_i) begin
                    cnt   <= '0;
                    hit_o <= hdr_match(nw);
                end else if (cnt == LAST_SLOT) begin
                    cnt         <= '0;
                    byte_done_o <= 1'b1;
                    byte_o      <= nw[8:1];
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: a byte completes only on a sample strobe
    p_done_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |-> $past(strobe_i));
    // R3: pattern hit and byte completion never coincide
    p_hit_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !byte_done_o);

endmodule

// File: rtl/idstream_store.sv
module idstream_store
    import idstream_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    logic [7:0] mem [REC_BYTES];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= 8'h00;
        end else if (re_i) begin
            rdata_o <= (int'(raddr_i) < HDR_BYTES) ? hdr_byte(int'(raddr_i)) : mem[raddr_i];
        end else begin
            rdata_o <= 8'h00;
        end
    end

    // R4: header slots are never overwritten by captured data
    p_no_hdr_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(waddr_i) >= HDR_BYTES));

endmodule

// File: rtl/idstream_rx.sv
module idstream_rx
    import idstream_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              ddc_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0]   TO_LAST   = TO_W'(TIMEOUT_CYC - 1);
    localparam logic [ADDR_W-1:0] IDX_FIRST = ADDR_W'(HDR_BYTES);
    localparam logic [ADDR_W-1:0] IDX_LAST  = ADDR_W'(REC_BYTES - 1);
    localparam logic [7:0]        SUM_INIT  = hdr_sum();

    rx_state_t         state, state_nx;
    logic              strobe, sbit;
    logic              hit, byte_done;
    logic [7:0]        byte_val;
    logic [TO_W-1:0]   timer;
    logic              to_hit;
    logic [ADDR_W-1:0] idx;
    logic [7:0]        sum_q;
    logic              wr_en;

    idstream_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync_i  (vsync_i),
        .data_i   (ddc_data_i),
        .strobe_o (strobe),
        .bit_o    (sbit)
    );

    idstream_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .bit_i       (sbit),
        .hunt_i      (state == ST_SEARCH),
        .clear_i     (to_hit),
        .hit_o       (hit),
        .byte_done_o (byte_done),
        .byte_o      (byte_val)
    );

    assign wr_en = (state == ST_CAPTURE) && byte_done;

    idstream_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (idx),
        .wdata_i (byte_val),
        .re_i    (rd_en_i && valid_o),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    assign to_hit = !strobe && (timer == TO_LAST);

    always_comb begin
        state_nx = state;
        if (to_hit) begin
            state_nx = ST_SEARCH;
        end else begin
            unique case (state)
                ST_SEARCH:  if (hit) state_nx = ST_CAPTURE;
                ST_CAPTURE: if (byte_done && idx == IDX_LAST) state_nx = ST_CHECK;
                ST_CHECK:   state_nx = (sum_q == 8'h00) ? ST_VALID : ST_SEARCH;
                ST_VALID:   state_nx = ST_VALID;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer   <= '0;
            idx     <= '0;
            sum_q   <= 8'h00;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            if (strobe || to_hit) timer <= '0;
            else                  timer <= timer + 1'b1;

            if (state == ST_SEARCH && hit) begin
                idx   <= IDX_FIRST;
                sum_q <= SUM_INIT;
            end else if (wr_en) begin
                idx   <= idx + 1'b1;
                sum_q <= sum_q + byte_val;
            end

            valid_o <= (state_nx == ST_VALID);
            err_o   <= !to_hit && (state == ST_CHECK) && (sum_q != 8'h00);
        end
    end

    // R1: state after reset release
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !valid_o);
    // R5: the flag rises only after a zero sum was held
    p_valid_after_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(sum_q) == 8'h00));
    // R6: error pulse lasts one cycle and excludes the valid flag
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    p_err_excl_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);
    // R7: a timeout always drops the valid flag
    p_timeout_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        to_hit |=> !valid_o);
    // R8: refused or absent reads return zero
    p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && valid_o) |=> (rd_data_o == 8'h00));
    // R4: capture index stays inside the data area
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |-> (int'(idx) >= HDR_BYTES));

endmodule

// File: tb/idstream_rx_bench.sv
module idstream_rx_bench;
    import idstream_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TO_CYC     = 400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vsync = 1'b0;
    logic              sdat = 1'b1;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              valid;
    logic              err;

    int n_chk = 0;
    int n_fail = 0;
    int err_cnt = 0;
    logic [7:0] gold [REC_BYTES];
    logic [7:0] exp_q [$];
    int         adr_q [$];
    logic       rd_seen = 1'b0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idstream_rx #(.TIMEOUT_CYC(TO_CYC)) u_idstream_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_i    (vsync),
        .ddc_data_i (sdat),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .valid_o    (valid),
        .err_o      (err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rst_n && err) err_cnt++;
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            int a;
            e = exp_q.pop_front();
            a = adr_q.pop_front();
            check($sformatf("R4 R8 read addr %0d", a), rd_data, e);
        end
    end

    // driver: request one read, expectation fixed by the flag in this cycle
    task automatic rd(input int a);
        @(posedge clk); #1;
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(a);
        exp_q.push_back(valid ? gold[a] : 8'h00);
        adr_q.push_back(a);
    endtask

    task automatic rd_stop();
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        sdat = b;
        repeat (2) @(posedge clk);
        #1 vsync = 1'b1;
        repeat (4) @(posedge clk);
        #1 vsync = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic spare);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(spare);
    endtask

    task automatic send_rec(input int from, input bit bad, input bit vary);
        for (int i = from; i < REC_BYTES; i++) begin
            logic [7:0] v;
            logic sp;
            v  = (bad && i == REC_BYTES - 1) ? gold[i] + 8'h01 : gold[i];
            sp = (vary && i >= HDR_BYTES) ? logic'(i % 2) : 1'b1;
            send_byte(v, sp);
        end
        repeat (6) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < REC_BYTES - 1; i++) begin
            gold[i] = (i < HDR_BYTES) ? hdr_byte(i) : 8'((i * 37 + 11) & 8'hFF);
            s = s + gold[i];
        end
        gold[REC_BYTES-1] = 8'h00 - s;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", valid, 0);
        check("R1 err", err, 0);
        check("R1 rd_data", rd_data, 0);

        // R8: read refused before any capture
        rd(5); rd(100); rd_stop();
        repeat (2) @(posedge clk);

        // R3: join mid-stream at byte 40, then a full record
        send_rec(40, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 no valid on partial record", valid, 0);
        send_rec(0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 R5 valid after aligned record", valid, 1);
        check("R5 no error", err_cnt, 0);

        // R4: read back every byte
        for (int a = 0; a < REC_BYTES; a++) rd(a);
        rd_stop();
        repeat (3) @(posedge clk);

        // R7 with R8: reads every cycle across the timeout
        for (int k = 0; k < TO_CYC + 40; k++) rd((k * 5) % REC_BYTES);
        rd_stop();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 valid cleared by timeout", valid, 0);
        check("R7 no error pulse on timeout", err_cnt, 0);

        // R6: bad checksum
        send_rec(0, 1'b1, 1'b0);
        @(negedge clk);
        check("R6 one error pulse", err_cnt, 1);
        check("R6 valid stays low", valid, 0);
        rd(9); rd_stop();
        repeat (2) @(posedge clk);

        // R2: spare bit varies, data unchanged
        send_rec(0, 1'b0, 1'b1);
        @(negedge clk);
        check("R2 valid with varying spare bits", valid, 1);
        check("R2 no further error", err_cnt, 1);
        for (int a = 0; a < 24; a++) rd(a);
        rd(REC_BYTES - 1);
        rd_stop();
        repeat (4) @(posedge clk);
        check("R8 scoreboard drained", exp_q.size(), 0);
        report();
    end

endmodule